// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises characters onto an asynchronous transmit line. A character written into its transmit storage is framed with a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Each bit is held for sixteen pulses of an external baud-tick strobe. Parity can be off, even, odd, or stuck at a constant value. A break control drives the line low for as long as it stays set.

The transmit storage is either a single holding register (character mode) or a small first-in first-out queue (queue mode). Busy, empty and full status are brought out as outputs. Transmission starts only while both the global enable and the transmit enable are high. If either enable drops during a character, that character still finishes. Busy stays high until the last stop bit has left the line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line `txd` is high, `tx_empty` is 1, and `busy` and `tx_full` are 0.
- R2: A frame is one low start bit, then the data bits least significant first (`wlen` code 00=5, 01=6, 10=7, 11=8 bits), then the optional parity bit, then the stop bits, which are high. Every bit lasts 16 `baud_tick` pulses.
- R3: With `par_en`=1 and `stick_par`=0, the data bits and the parity bit together hold an even number of ones when `even_sel`=1 and an odd number when `even_sel`=0. With `par_en`=0, no parity bit is sent.
- R4: With `par_en`=1 and `stick_par`=1, the parity bit is the inverse of `even_sel`, whatever the data.
- R5: With `two_stop`=1, each frame ends with two high stop bits instead of one.
- R6: While `brk`=1, a character already in flight finishes unchanged. The line is then held low, and no new character starts until `brk` returns to 0.
- R7: `busy` is 1 whenever the storage holds a character, even with transmission disabled. It stays 1 until the last stop bit of the character in flight has ended.
- R8: Dropping `tx_en` or `global_en` in the middle of a character does not cut that character short. While either enable is 0, no new character starts.
- R9: With `fifo_mode`=0, the storage is a single holding register. `tx_full` is 1 while it holds a character, a write made while it is full is discarded, and `tx_empty` returns to 1 as soon as the character moves into the shifter.
- R10: With `fifo_mode`=1, the storage holds DEPTH characters and sends them in write order. `tx_full` is 1 at DEPTH characters, and a write made while full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per sixteenth of a bit period |
| global_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| fifo_mode | input | 1 | 1 = queue storage, 0 = single holding register |
| wlen | input | 2 | Word length code |
| par_en | input | 1 | Parity bit enable |
| even_sel | input | 1 | Even parity select |
| stick_par | input | 1 | Constant parity bit select |
| two_stop | input | 1 | Two stop bits select |
| brk | input | 1 | Force the line low once idle |
| wr_valid | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to write |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | Storage non-empty or shifter active |
| tx_empty | output | 1 | Storage holds no character |
| tx_full | output | 1 | Storage cannot accept a write |

## Verification
A write shows on `busy`, `tx_empty` and `tx_full` one clock after its strobe. When the enables allow it, the start bit appears on `txd` one clock after that. Later bit boundaries follow 16 tick pulses after the previous one, but the first bit can be up to one tick period short, because the tick phase is free at load time. For this reason the bench finds the falling edge of the start bit and samples each bit at its nominal middle. Any error smaller than half a bit still leaves the sample inside the correct bit. Checks for idle line and status after a frame are made one half bit plus two clocks after the middle of the last stop bit, which is past the end of the frame.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    localparam int FRAME_W = 12;
    localparam int LEN_W   = 4;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       even_sel;
        logic       stick;
        logic       two_stop;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    // Lay out one frame, bit 0 first on the line.
    function automatic frame_t make_frame(input logic [7:0] data, input fmt_t f);
        frame_t r;
        int     nd;
        logic   p;
        nd     = 5 + int'(f.wlen);
        r.bits = '1;
        r.bits[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < nd) begin
                r.bits[i+1] = data[i];
                p = p ^ data[i];
            end
        end
        if (f.par_en) begin
            r.bits[nd+1] = f.stick ? ~f.even_sel : (f.even_sel ? p : ~p);
        end
        r.len = LEN_W'(2 + nd + int'(f.par_en) + int'(f.two_stop));
        return r;
    endfunction

endpackage

// File: rtl/uftx_store.sv
module uftx_store #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_mode,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] head,
    output logic       empty,
    output logic       full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         rd;
        logic [AW-1:0]         wr;
        logic [AW:0]           cnt;
    } st_t;

    st_t  st_d, st_q;
    logic do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = fifo_mode ? (st_q.cnt == (AW+1)'(DEPTH)) : !empty;
    assign head  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uftx_shift.sv
module uftx_shift
    import uftx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   baud_tick,
    input  logic   load,
    input  frame_t frame,
    output logic   active,
    output logic   line
);
    typedef struct packed {
        logic               act;
        logic [FRAME_W-1:0] sh;
        logic [LEN_W-1:0]   left;
        logic [3:0]         tcnt;
    } st_t;

    st_t st_d, st_q;

    assign active = st_q.act;
    assign line   = st_q.sh[0];

    always_comb begin
        st_d = st_q;
        if (!st_q.act) begin
            if (load) begin
                st_d.act  = 1'b1;
                st_d.sh   = frame.bits;
                st_d.left = frame.len;
                st_d.tcnt = '0;
            end
        end else if (baud_tick) begin
            st_d.tcnt = st_q.tcnt + 1'b1;
            if (st_q.tcnt == 4'hf) begin
                st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                st_d.left = st_q.left - 1'b1;
                if (st_q.left == LEN_W'(1)) st_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{act: 1'b0, sh: '1, left: '0, tcnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       global_en,
    input  logic       tx_en,
    input  logic       fifo_mode,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       even_sel,
    input  logic       stick_par,
    input  logic       two_stop,
    input  logic       brk,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       txd,
    output logic       busy,
    output logic       tx_empty,
    output logic       tx_full
);
    logic [7:0] head;
    logic       st_empty;
    logic       sh_act;
    logic       sh_line;
    logic       load;
    fmt_t       fmt;
    frame_t     frame;

    always_comb begin
        fmt   = '{wlen: wlen, par_en: par_en, even_sel: even_sel,
                  stick: stick_par, two_stop: two_stop};
        frame = make_frame(head, fmt);
        load  = !sh_act && !st_empty && global_en && tx_en && !brk;
    end

    uftx_store #(.DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .push      (wr_valid),
        .push_data (wr_data),
        .pop       (load),
        .head      (head),
        .empty     (st_empty),
        .full      (tx_full)
    );

    uftx_shift shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .load      (load),
        .frame     (frame),
        .active    (sh_act),
        .line      (sh_line)
    );

    assign txd      = sh_act ? sh_line : !brk;
    assign busy     = sh_act || !st_empty;
    assign tx_empty = st_empty;
endmodule

// File: rtl/uftx_checker.sv
module uftx_checker (
    input logic clk,
    input logic rst_n,
    input logic global_en,
    input logic tx_en,
    input logic brk,
    input logic txd,
    input logic busy,
    input logic tx_empty,
    input logic tx_full,
    input logic shift_act
);
    // R1: with nothing in flight and no break, the line is high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_act && !brk) |-> txd);
    // R2: a frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_act) |-> !txd);
    // R6: break holds the idle line low and keeps the shifter idle
    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_act && brk) |-> !txd);
    a_r6_break_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_act && brk) |=> !shift_act);
    // R7: stored data keeps busy high
    a_r7_busy_stored: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_empty |-> busy);
    // R8: no new character while an enable is low
    a_r8_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_act && !(global_en && tx_en)) |=> !shift_act);
    // R9: full storage is never empty
    a_r9_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_empty);
endmodule

bind uart_frame_tx uftx_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .global_en (global_en),
    .tx_en     (tx_en),
    .brk       (brk),
    .txd       (txd),
    .busy      (busy),
    .tx_empty  (tx_empty),
    .tx_full   (tx_full),
    .shift_act (sh_act)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       global_en = 1'b1;
    logic       tx_en = 1'b0;
    logic       fifo_mode = 1'b0;
    logic [1:0] wlen = 2'b11;
    logic       par_en = 1'b0;
    logic       even_sel = 1'b0;
    logic       stick_par = 1'b0;
    logic       two_stop = 1'b0;
    logic       brk = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, busy, tx_empty, tx_full;

    int total = 0;
    int bad = 0;
    int per = 1;
    int tick_ctr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tick_ctr = (tick_ctr >= per - 1) ? 0 : tick_ctr + 1;
        baud_tick = (tick_ctr == 0);
    end

    uart_frame_tx #(.DEPTH(DEPTH)) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected line bits for one frame, index 0 leaves first.
    function automatic int exp_frame(input logic [7:0] d, output logic [11:0] b);
        int n, k, ones;
        n = int'(wlen) + 5;
        b = '1;
        b[0] = 1'b0;
        ones = 0;
        for (int j = 0; j < n; j++) begin
            b[j+1] = d[j];
            if (d[j]) ones++;
        end
        k = n + 1;
        if (par_en) begin
            if (stick_par) b[k] = !even_sel;
            else if (even_sel) b[k] = (ones % 2 == 1);
            else b[k] = (ones % 2 == 0);
            k++;
        end
        return k + (two_stop ? 2 : 1);
    endfunction

    task automatic wr(input logic [7:0] d);
        wr_valid = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Wait for a start bit and compare every bit at its middle.
    task automatic recv(input logic [7:0] d, input string tag);
        logic [11:0] eb;
        int len, w;
        len = exp_frame(d, eb);
        w = 0;
        while (txd !== 1'b0 && w < 4000) begin
            @(negedge clk);
            w++;
        end
        chk(txd === 1'b0, {tag, " start"}, int'(txd), 0);
        repeat (8 * per) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            if (i > 0) repeat (16 * per) @(negedge clk);
            chk(txd === eb[i], $sformatf("%s bit%0d", tag, i), int'(txd), int'(eb[i]));
        end
    endtask

    task automatic after_frame;
        repeat (8 * per + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b1 && busy === 1'b0 && tx_full === 1'b0,
            "R1 reset state", {txd, tx_empty, busy, tx_full}, 4'b1100);

        // Character mode, transmit disabled
        wr(8'ha5);
        chk(busy === 1'b1 && tx_empty === 1'b0, "R7 busy while disabled", {busy, tx_empty}, 2'b10);
        chk(tx_full === 1'b1, "R9 holding full", int'(tx_full), 1);
        wr(8'h3c);
        repeat (20) @(negedge clk);
        chk(txd === 1'b1, "R8 no start while disabled", int'(txd), 1);
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_empty === 1'b1 && busy === 1'b1, "R9 empty excludes shifter", {tx_empty, busy}, 2'b11);
        recv(8'ha5, "R2 8N1");
        after_frame();
        chk(busy === 1'b0 && txd === 1'b1, "R7 busy falls after stop", {busy, txd}, 2'b01);
        repeat (40) @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b1, "R9 write while full discarded", {txd, tx_empty}, 2'b11);

        // Directed formats
        per = 2;
        fifo_mode = 1'b1;
        wlen = 2'b00; par_en = 1'b1; even_sel = 1'b1;
        wr(8'he7); recv(8'he7, "R3 5E1");
        even_sel = 1'b0;
        wr(8'h0b); recv(8'h0b, "R3 5O1");
        wlen = 2'b10; stick_par = 1'b1; even_sel = 1'b0;
        wr(8'h55); recv(8'h55, "R4 stick one");
        even_sel = 1'b1;
        wr(8'h2a); recv(8'h2a, "R4 stick zero");
        stick_par = 1'b0; par_en = 1'b0; wlen = 2'b01; two_stop = 1'b1;
        wr(8'h3f); recv(8'h3f, "R5 6N2");
        after_frame();
        two_stop = 1'b0; wlen = 2'b11;

        // Break
        wr(8'h81);
        repeat (4) @(negedge clk);
        brk = 1'b1;
        recv(8'h81, "R6 frame under break");
        after_frame();
        chk(txd === 1'b0, "R6 line low after frame", int'(txd), 0);
        wr(8'h42);
        repeat (100) @(negedge clk);
        chk(txd === 1'b0 && busy === 1'b1 && tx_empty === 1'b0, "R6 held off",
            {txd, busy, tx_empty}, 3'b010);
        brk = 1'b0;
        recv(8'h42, "R6 after break");
        after_frame();

        // Disable in mid character
        wr(8'hc3); wr(8'h18);
        fork
            recv(8'hc3, "R8 finish on disable");
            begin repeat (60 * per) @(negedge clk); tx_en = 1'b0; end
        join
        after_frame();
        repeat (60) @(negedge clk);
        chk(txd === 1'b1 && busy === 1'b1, "R8 R7 stopped with data", {txd, busy}, 2'b11);
        global_en = 1'b0; tx_en = 1'b1;
        repeat (60) @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b0, "R8 global enable off", {txd, tx_empty}, 2'b10);
        global_en = 1'b1;
        recv(8'h18, "R8 resume");
        after_frame();

        // Queue depth and order
        per = 1;
        tx_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) wr(8'(8'h10 + i));
        chk(tx_full === 1'b1, "R10 full at depth", int'(tx_full), 1);
        wr(8'hee);
        tx_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) recv(8'(8'h10 + i), $sformatf("R10 order %0d", i));
        after_frame();
        chk(busy === 1'b0 && tx_empty === 1'b1, "R10 extra write discarded", {busy, tx_empty}, 2'b01);

        // Random formats and data
        void'($urandom(32'h1234));
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d;
            per = 1 + int'($urandom % 3);
            wlen = 2'($urandom); par_en = 1'($urandom); even_sel = 1'($urandom);
            stick_par = 1'($urandom); two_stop = 1'($urandom);
            d = 8'($urandom);
            wr(d);
            recv(d, "R2 R3 R4 R5 random");
            after_frame();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule